// File: doc/BRIEF.md
# Output-Compare Timer Channel with Deferred Value Loading

This block is one compare channel sitting on a free-running up-counter. Software programs a compare value through a byte-wide register port, high byte first. Each time the counter steps onto the value held in the active compare register, the channel raises its event flag. Depending on the channel mode, the channel then requests an interrupt and drives its output pin high.

Loading a new compare value depends on the state of the timer clock. When the clock-select input is all zero, the timer is halted and a completed value write lands in the active register straight away. When the timer runs, the value waits in a holding register and moves across on the first counter step after the write. A write to the channel control register while a value is waiting throws the waiting value away. The event flag is cleared by a read-then-write handshake, so a single stray write cannot clear it.

Top module: `tmr_ochan`

## Requirements
- R1: After reset the control byte reads 0x00, the active compare value reads 0x0000, the counter reads 0x0000, and the output pin and interrupt request are low.
- R2: The counter advances by one in every clock cycle in which cnt_tick is high and clk_sel is non-zero. It holds otherwise, and changing clk_sel never resets it.
- R3: With mode bits 5:4 = 01, the flag (control bit 7) reads 1 in the cycle after a counter step whose new value equals the active compare value. With any other mode value, a match never sets the flag.
- R4: The flag clears only through a write to the control byte with bit 7 = 0 that follows a read of the control byte made while the flag was 1. A control write without that earlier read leaves the flag set.
- R5: irq is high exactly while both the flag and the interrupt-enable bit (control bit 6) are 1.
- R6: cmp_pin is low from reset. With mode 01 and edge/level bits 3:2 = 10, a match drives it high and it stays high. With bits 3:2 = 00, a match leaves it unchanged.
- R7: While clk_sel is 00, writing the high byte (address 1) and then the low byte (address 2) makes the new value readable at those addresses from the next cycle on.
- R8: While the timer runs, a low-byte write leaves the old active value in place. The new value is loaded at the first counter step in a later cycle and is readable after that step.
- R9: A high-byte write on its own changes neither the active value nor any waiting value.
- R10: A control-byte write made while a value is waiting discards that value, so the active value stays unchanged through later counter steps.
- R11: Reads return: address 0 the control byte {flag, enable, mode[1:0], edge[1:0], aux[1:0]}; address 1 and address 2 the high and low bytes of the active value; address 3 and address 4 the high and low bytes of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Timer clock select; 00 halts the counter |
| cnt_tick | input | 1 | Counter step enable from the prescaler |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| cmp_pin | output | 1 | Channel output pin |
| irq | output | 1 | Channel interrupt request |

## Verification
The assertions assume that at most one of bus_wr and bus_rd is high in any cycle. They also assume that clk_sel and cnt_tick change only between clock edges, so each counter step is a single registered event. The stimulus issues one bus access at a time, each lasting exactly one cycle. It raises cnt_tick only in cycles where no bus access is in flight, which keeps write-versus-step ordering unambiguous for the deferred-load checks.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_VHI  = 3'd1;
    localparam logic [2:0] ADR_VLO  = 3'd2;
    localparam logic [2:0] ADR_CHI  = 3'd3;
    localparam logic [2:0] ADR_CLO  = 3'd4;

    localparam logic [1:0] MODE_SWCMP = 2'b01;
    localparam logic [1:0] EDGE_SET   = 2'b10;

    typedef struct packed {
        logic       flag;
        logic       ien;
        logic [1:0] mode;
        logic [1:0] edge_sel;
        logic [1:0] aux;
    } ctrl_t;

endpackage

// File: rtl/tc_counter.sv
module tc_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        step    = run && tick;
        cnt_nxt = s_q.cnt + 1'b1;
        if (step) begin
            s_d.cnt = cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tc_cmp_buffer.sv
module tc_cmp_buffer #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  active
);

    typedef struct packed {
        logic [BYTE_W-1:0] hi_buf;
        logic [CNT_W-1:0]  pend_val;
        logic              pend;
        logic [CNT_W-1:0]  active;
    } buf_st_t;

    buf_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hi_wr) begin
            s_d.hi_buf = wdata;
        end
        if (lo_wr) begin
            if (!run) begin
                s_d.active = {s_q.hi_buf, wdata};
                s_d.pend   = 1'b0;
            end else begin
                s_d.pend_val = {s_q.hi_buf, wdata};
                s_d.pend     = 1'b1;
            end
        end else if (ctrl_wr) begin
            s_d.pend = 1'b0;
        end else if (s_q.pend && step) begin
            s_d.active = s_q.pend_val;
            s_d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;

    assert_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !s_q.pend);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && !(s_q.pend && step)) |=> $stable(active));

    assert_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && run) |=> $stable(active));

endmodule

// File: rtl/tc_channel.sv
module tc_channel #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic [CNT_W-1:0]  active,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic [BYTE_W-1:0] wdata,
    output tc_pkg::ctrl_t     ctrl,
    output logic              pin,
    output logic              irq
);
    import tc_pkg::*;

    typedef struct packed {
        ctrl_t ctrl;
        logic  armed;
        logic  pin;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   match;
    logic   clr;

    always_comb begin
        s_d   = s_q;
        match = step && (cnt_nxt == active) && (s_q.ctrl.mode == MODE_SWCMP);
        clr   = ctrl_wr && s_q.armed && !wdata[BYTE_W-1];
        if (ctrl_wr) begin
            s_d.ctrl.ien      = wdata[6];
            s_d.ctrl.mode     = wdata[5:4];
            s_d.ctrl.edge_sel = wdata[3:2];
            s_d.ctrl.aux      = wdata[1:0];
            s_d.armed         = 1'b0;
        end else if (ctrl_rd && s_q.ctrl.flag) begin
            s_d.armed = 1'b1;
        end
        if (match) begin
            s_d.ctrl.flag = 1'b1;
            if (s_q.ctrl.edge_sel == EDGE_SET) begin
                s_d.pin = 1'b1;
            end
        end else if (clr) begin
            s_d.ctrl.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl = s_q.ctrl;
    assign pin  = s_q.pin;
    assign irq  = s_q.ctrl.flag && s_q.ctrl.ien;

    assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.flag) |-> $past(step && (cnt_nxt == active)));

    assert_flag_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.flag) |-> $past(ctrl_wr && s_q.armed));

    assert_pin_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(pin));

    assert_irq_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl.flag);

endmodule

// File: rtl/tmr_ochan.sv
module tmr_ochan #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        clk_sel,
    input  logic              cnt_tick,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              cmp_pin,
    output logic              irq
);
    import tc_pkg::*;

    logic             run, step;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, active;
    logic             ctrl_wr, ctrl_rd, hi_wr, lo_wr;
    ctrl_t            ctrl;

    always_comb begin
        run     = |clk_sel;
        ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
        ctrl_rd = bus_rd && (bus_addr == ADR_CTRL);
        hi_wr   = bus_wr && (bus_addr == ADR_VHI);
        lo_wr   = bus_wr && (bus_addr == ADR_VLO);
    end

    tc_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (cnt_tick),
        .step    (step),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    tc_cmp_buffer #(.BYTE_W(BYTE_W)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (step),
        .hi_wr   (hi_wr),
        .lo_wr   (lo_wr),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .active  (active)
    );

    tc_channel #(.BYTE_W(BYTE_W)) i_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .cnt_nxt (cnt_nxt),
        .active  (active),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .wdata   (bus_wdata),
        .ctrl    (ctrl),
        .pin     (cmp_pin),
        .irq     (irq)
    );

    always_comb begin
        unique case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl;
            ADR_VHI:  bus_rdata = active[CNT_W-1:BYTE_W];
            ADR_VLO:  bus_rdata = active[BYTE_W-1:0];
            ADR_CHI:  bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            ADR_CLO:  bus_rdata = cnt_q[BYTE_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end

    assert_bus_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

endmodule

// File: tb/test_tmr_ochan.sv
module test_tmr_ochan;

    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       cnt_tick = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_pin, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_T/2) clk = ~clk;

    tmr_ochan i_tmr_ochan (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .cnt_tick  (cnt_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_pin   (cmp_pin),
        .irq       (irq)
    );

    // monitor: pops expected read data and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_T/4);
            if (bus_rd) begin
                item_t it;
                n_chk++;
                if (sb_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s: unexpected read, actual %02h expected none", "R11", bus_rdata);
                end else begin
                    it = sb_q.pop_front();
                    if (bus_rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: read actual %02h expected %02h", it.tag, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic chk(input string tag, input logic act, input logic e);
        #1;
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, e);
        end
    endtask

    task automatic finish_up();
        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: %0d reads never seen, expected 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 8'h00, "R1");
        rd(3'd1, 8'h00, "R1");
        rd(3'd2, 8'h00, "R1");
        rd(3'd4, 8'h00, "R1");
        chk("R1", cmp_pin, 1'b0);
        chk("R1", irq, 1'b0);

        // R7 immediate load while halted
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h05);
        rd(3'd2, 8'h05, "R7");
        wr(3'd0, 8'h50);
        ticks(3);
        rd(3'd4, 8'h00, "R2");   // halted: counter holds
        clk_sel = 2'b01;
        ticks(5);
        rd(3'd4, 8'h05, "R2");
        chk("R5", irq, 1'b1);
        chk("R6", cmp_pin, 1'b0);

        // R4 write without prior read keeps flag
        wr(3'd0, 8'h50);
        chk("R4", irq, 1'b1);
        rd(3'd0, 8'hD0, "R3");
        wr(3'd0, 8'h50);
        rd(3'd0, 8'h50, "R4");
        chk("R5", irq, 1'b0);

        // R2 clock select change does not reset counter
        clk_sel = 2'b10;
        rd(3'd4, 8'h05, "R2");
        rd(3'd3, 8'h00, "R11");
        clk_sel = 2'b01;

        // R9 / R8 deferred load
        wr(3'd1, 8'h12);
        rd(3'd1, 8'h00, "R9");
        wr(3'd2, 8'h0A);
        rd(3'd1, 8'h00, "R8");
        rd(3'd2, 8'h05, "R8");
        ticks(1);
        rd(3'd1, 8'h12, "R8");
        rd(3'd2, 8'h0A, "R8");

        // R10 control write cancels waiting value
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h08);
        wr(3'd0, 8'h50);
        ticks(3);
        rd(3'd1, 8'h12, "R10");
        rd(3'd2, 8'h0A, "R10");
        rd(3'd0, 8'h50, "R10");

        // R6 set-on-compare
        clk_sel = 2'b00;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h0C);
        wr(3'd0, 8'h18);
        chk("R6", cmp_pin, 1'b0);
        clk_sel = 2'b01;
        ticks(3);
        chk("R6", cmp_pin, 1'b1);
        chk("R5", irq, 1'b0);
        rd(3'd0, 8'h98, "R3");
        wr(3'd0, 8'h18);
        rd(3'd0, 8'h18, "R4");
        chk("R6", cmp_pin, 1'b1);

        // R3 other mode never flags
        clk_sel = 2'b00;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h10);
        wr(3'd0, 8'h03);
        clk_sel = 2'b01;
        ticks(4);
        rd(3'd4, 8'h10, "R2");
        rd(3'd0, 8'h03, "R3");

        repeat (2) @(negedge clk);
        done = 1;
        finish_up();
    end

endmodule